// File: doc/BRIEF.md
# Issue-Stage Wait-State Hazard Calculator

This block sits at the issue point of an in-order shader pipeline and decides how many idle cycles a candidate instruction must wait before it may issue. It keeps a five-slot record of what issued recently, newest first. An instruction that takes several wait states, or an inserted no-op, fills slots with empty entries, so the position of a recorded instruction in the window is its distance in wait states from the candidate.

Each recorded entry keeps its instruction class, up to four registers, a hardware-register ID and two store qualifiers. The candidate is presented combinationally as a class, four source registers, four destination registers and a hardware-register ID. A set of class-pair distance rules is evaluated against the window. For every rule the required stall is the rule value minus the index of the newest matching slot, floored at zero. The output is the largest of these values together with a flag that is set when that value is nonzero.

Register indices are 8 bits wide: bit 7 set means a vector register and bit 7 clear means a scalar register. The execution mask is scalar index 0x7E and the VCC flag register is scalar index 0x6A. Class codes are 0 other, 1 scalar ALU, 2 vector ALU, 3 scalar memory read, 4 vector memory, 5 data-parallel permute, 6 fused divide-scale, 7 lane read/write, 8 hardware-register read, 9 hardware-register write, 10 return-from-exception, 11 placeholder and 12 debug. Codes 2, 5, 6 and 7 count as vector-ALU writers. The trap-status hardware-register ID is 3.

Top module: `hzc_waitcalc`

## Requirements
- R1: An issue of class code 0 to 10 with wait count N records the instruction at slot min(max(N,1),5)-1. Slots newer than it become empty and older entries shift down by the same amount. Entries pushed beyond slot 4 are lost, so N of 5 or more leaves only slot 4 filled.
- R2: A cycle with neither an issue nor a no-op leaves the window unchanged. An issue with class code 11 (placeholder) or 12 (debug) is not recorded.
- R3: A no-op request pushes one empty slot. When an issue and a no-op request come in the same cycle, only the issue is recorded.
- R4: A scalar memory read (class 3) with a valid scalar source that a vector-ALU writer recorded at slot i needs max(4-i,0). The newest matching slot is used.
- R5: A vector memory op (class 4) with a valid scalar source written by a vector-ALU writer at slot i needs max(5-i,0). Vector sources do not take part in this rule.
- R6: A permute op (class 5) with a valid vector source written at slot i by any entry that is not a store needs max(2-i,0).
- R7: A permute op needs max(5-i,0), where i is the newest slot at which a vector-ALU writer wrote register 0x7E.
- R8: A divide-scale op (class 6) needs max(4-i,0) after a vector-ALU writer wrote register 0x6A at slot i.
- R9: A lane op (class 7) whose source 1 is a valid scalar register written by a vector-ALU writer at slot i needs max(4-i,0). Its other sources do not take part in this rule.
- R10: A hardware-register read (class 8) needs max(2-i,0) after a hardware-register write (class 9) with the same ID at slot i. A hardware-register write with the same ID needs max(W-i,0), where W is 1 when gen_sel is 0 and 2 when gen_sel is 1.
- R11: A return-from-exception (class 10) needs max(1-i,0) after a hardware-register write to ID 3 at slot i.
- R12: While store_hz_en is 1, a vector-ALU-writer candidate whose valid vector destination matches a data register of a store at slot i needs max(1-i,0). This applies only to stores with wide data and no register offset.
- R13: The stall output is the maximum over all rules and operands, and the hazard output is 1 exactly when the stall is nonzero. Reset empties the window, so every candidate then needs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_class | input | 4 | Class code of the issuing instruction |
| iss_regs | input | 4x8 | Registers written, or data registers for a store |
| iss_reg_vld | input | 4 | Valid bit per entry of iss_regs |
| iss_hwid | input | 6 | Hardware-register ID targeted |
| iss_waits | input | 3 | Wait-state length of the issuing instruction |
| iss_store | input | 1 | Issuing instruction is a store |
| iss_data_wide | input | 1 | Store data wider than 64 bits |
| iss_soff_reg | input | 1 | Store uses a register offset operand |
| nop_valid | input | 1 | Inserted no-op this cycle |
| gen_sel | input | 1 | Selects the hardware-register write-after-write distance |
| store_hz_en | input | 1 | Enables the wide-store overwrite rule |
| cand_class | input | 4 | Candidate class code |
| cand_src | input | 4x8 | Candidate source registers |
| cand_src_vld | input | 4 | Valid bit per source |
| cand_dst | input | 4x8 | Candidate destination registers |
| cand_dst_vld | input | 4 | Valid bit per destination |
| cand_hwid | input | 6 | Candidate hardware-register ID |
| stall | output | 3 | Required idle cycles |
| hazard | output | 1 | Stall is nonzero |

## Verification
The window updates on the clock edge at which an issue or no-op is presented, and stall and hazard are combinational from the window and the candidate. A result is therefore due in the same cycle the candidate is applied, reflecting every push up to the previous edge. The bench presents pushes at the falling edge and lets exactly one rising edge pass per push. It then applies the candidate at the following falling edge and samples one time unit later, well clear of the next rising edge. Distances are moved by idle cycles, which must change nothing, and by no-ops, which must lower each result by exactly one.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int HIST  = 5;   // window slots
  localparam int NREG  = 4;   // register entries per slot / operands
  localparam int RW    = 8;   // register index width
  localparam int HWW   = 6;   // hardware-register ID width
  localparam int CW    = 4;   // class code width
  localparam int SW    = 3;   // stall / wait-count width

  localparam logic [RW-1:0]  EXEC_ID = 8'h7E;
  localparam logic [RW-1:0]  VCC_ID  = 8'h6A;
  localparam logic [HWW-1:0] TRAP_ID = 6'd3;

  typedef enum logic [CW-1:0] {
    C_OTHER = 4'd0, C_SALU = 4'd1, C_VALU = 4'd2, C_SMEM = 4'd3,
    C_VMEM  = 4'd4, C_DPP  = 4'd5, C_DIV  = 4'd6, C_LANE = 4'd7,
    C_HWRD  = 4'd8, C_HWWR = 4'd9, C_RFE  = 4'd10, C_PH = 4'd11,
    C_DBG   = 4'd12, C_R13 = 4'd13, C_R14 = 4'd14, C_R15 = 4'd15
  } icls_e;

  typedef struct packed {
    logic                     vld;
    icls_e                    cls;
    logic [NREG-1:0][RW-1:0]  regs;
    logic [NREG-1:0]          rvld;
    logic [HWW-1:0]           hwid;
    logic                     is_store;
    logic                     hz_store;
  } slot_t;

  function automatic logic valu_like(icls_e c);
    return (c == C_VALU) || (c == C_DPP) || (c == C_DIV) || (c == C_LANE);
  endfunction

  function automatic logic is_vec(logic [RW-1:0] r);
    return r[RW-1];
  endfunction

  // slot holds register r in its list (any valid entry)
  function automatic logic holds_reg(slot_t s, logic [RW-1:0] r);
    logic h;
    h = 1'b0;
    for (int j = 0; j < NREG; j++) begin
      if (s.rvld[j] && (s.regs[j] == r)) h = 1'b1;
    end
    return h;
  endfunction
endpackage

// File: rtl/hzc_history.sv
module hzc_history
  import hzc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  slot_t         push_slot,
  input  logic [SW-1:0] push_waits,
  input  logic          nop_en,
  output slot_t         hist [HIST]
);
  localparam int KW = SW + 1;

  slot_t          hist_q  [HIST];
  slot_t          hist_nx [HIST];
  logic           hist_en;
  logic [KW-1:0]  shift_k;
  logic [HIST-1:0] vld_q;

  // next-state
  always_comb begin
    hist_en = 1'b0;
    shift_k = '0;
    for (int i = 0; i < HIST; i++) hist_nx[i] = hist_q[i];
    if (push_en) begin
      hist_en = 1'b1;
      if (push_waits == '0)                       shift_k = KW'(1);
      else if (int'(push_waits) > HIST)           shift_k = KW'(HIST);
      else                                        shift_k = KW'(push_waits);
      for (int i = 0; i < HIST; i++) begin
        if (i < int'(shift_k) - 1)       hist_nx[i] = '0;
        else if (i == int'(shift_k) - 1) hist_nx[i] = push_slot;
        else                             hist_nx[i] = hist_q[i - int'(shift_k)];
      end
    end else if (nop_en) begin
      hist_en    = 1'b1;
      hist_nx[0] = '0;
      for (int i = 1; i < HIST; i++) hist_nx[i] = hist_q[i-1];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
    end else if (hist_en) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= hist_nx[i];
    end
  end

  always_comb begin
    for (int i = 0; i < HIST; i++) begin
      hist[i]  = hist_q[i];
      vld_q[i] = hist_q[i].vld;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && !nop_en) |=> $stable(vld_q));

  // R3
  nop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nop_en && !push_en) |=> (!vld_q[0] && (vld_q[HIST-1:1] == $past(vld_q[HIST-2:0]))));

  // R1
  long_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && (int'(push_waits) >= HIST)) |=> (vld_q == (HIST'(1) << (HIST-1))));
endmodule

// File: rtl/hzc_dist.sv
module hzc_dist
  import hzc_pkg::*;
#(
  parameter int DEPTH = HIST
) (
  input  logic [DEPTH-1:0] hit,
  input  logic [SW-1:0]    rule,
  output logic [SW-1:0]    need
);
  logic found;

  // newest matching slot sets the distance
  always_comb begin
    need  = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && hit[i]) begin
        found = 1'b1;
        if (int'(rule) > i) need = SW'(int'(rule) - i);
      end
    end
  end
endmodule

// File: rtl/hzc_rules.sv
module hzc_rules
  import hzc_pkg::*;
(
  input  slot_t                    hist [HIST],
  input  icls_e                    c_cls,
  input  logic [NREG-1:0][RW-1:0]  c_src,
  input  logic [NREG-1:0]          c_src_vld,
  input  logic [NREG-1:0][RW-1:0]  c_dst,
  input  logic [NREG-1:0]          c_dst_vld,
  input  logic [HWW-1:0]           c_hwid,
  input  logic                     gen_sel,
  input  logic                     store_hz_en,
  output logic [SW-1:0]            stall
);
  localparam int NSRC = NREG * 2;           // per-source searches
  localparam int NFIX = 4;                  // exec, vcc, hw id, trap
  localparam int NALL = NSRC + NFIX + NREG; // plus per-destination

  logic [SW-1:0] need_all [NALL];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_src
      logic [HIST-1:0] hv, ha;
      logic [SW-1:0]   rv, ra;
      always_comb begin
        for (int i = 0; i < HIST; i++) begin
          hv[i] = hist[i].vld && valu_like(hist[i].cls) && holds_reg(hist[i], c_src[g]);
          ha[i] = hist[i].vld && !hist[i].is_store && holds_reg(hist[i], c_src[g]);
        end
        rv = '0;
        if (c_src_vld[g] && !is_vec(c_src[g])) begin
          if (c_cls == C_SMEM)                 rv = SW'(4);
          else if (c_cls == C_VMEM)            rv = SW'(5);
          else if (c_cls == C_LANE && g == 1)  rv = SW'(4);
        end
        ra = (c_cls == C_DPP && c_src_vld[g] && is_vec(c_src[g])) ? SW'(2) : '0;
      end
      hzc_dist u_dv (.hit(hv), .rule(rv), .need(need_all[2*g]));
      hzc_dist u_da (.hit(ha), .rule(ra), .need(need_all[2*g+1]));
    end

    for (g = 0; g < NREG; g++) begin : g_dst
      logic [HIST-1:0] hs;
      logic [SW-1:0]   rs;
      always_comb begin
        for (int i = 0; i < HIST; i++)
          hs[i] = hist[i].vld && hist[i].hz_store && holds_reg(hist[i], c_dst[g]);
        rs = (store_hz_en && valu_like(c_cls) && c_dst_vld[g] && is_vec(c_dst[g])) ? SW'(1) : '0;
      end
      hzc_dist u_ds (.hit(hs), .rule(rs), .need(need_all[NSRC+NFIX+g]));
    end
  endgenerate

  logic [HIST-1:0] h_exec, h_vcc, h_hw, h_trap;
  logic [SW-1:0]   r_exec, r_vcc, r_hw, r_trap;

  always_comb begin
    for (int i = 0; i < HIST; i++) begin
      h_exec[i] = hist[i].vld && valu_like(hist[i].cls) && holds_reg(hist[i], EXEC_ID);
      h_vcc[i]  = hist[i].vld && valu_like(hist[i].cls) && holds_reg(hist[i], VCC_ID);
      h_hw[i]   = hist[i].vld && (hist[i].cls == C_HWWR) && (hist[i].hwid == c_hwid);
      h_trap[i] = hist[i].vld && (hist[i].cls == C_HWWR) && (hist[i].hwid == TRAP_ID);
    end
    r_exec = (c_cls == C_DPP) ? SW'(5) : '0;
    r_vcc  = (c_cls == C_DIV) ? SW'(4) : '0;
    r_trap = (c_cls == C_RFE) ? SW'(1) : '0;
    if (c_cls == C_HWRD)      r_hw = SW'(2);
    else if (c_cls == C_HWWR) r_hw = gen_sel ? SW'(2) : SW'(1);
    else                      r_hw = '0;
  end

  hzc_dist u_exec (.hit(h_exec), .rule(r_exec), .need(need_all[NSRC]));
  hzc_dist u_vcc  (.hit(h_vcc),  .rule(r_vcc),  .need(need_all[NSRC+1]));
  hzc_dist u_hw   (.hit(h_hw),   .rule(r_hw),   .need(need_all[NSRC+2]));
  hzc_dist u_trap (.hit(h_trap), .rule(r_trap), .need(need_all[NSRC+3]));

  always_comb begin
    stall = '0;
    for (int k = 0; k < NALL; k++)
      if (need_all[k] > stall) stall = need_all[k];
  end
endmodule

// File: rtl/hzc_waitcalc.sv
module hzc_waitcalc
  import hzc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [CW-1:0]            iss_class,
  input  logic [NREG-1:0][RW-1:0]  iss_regs,
  input  logic [NREG-1:0]          iss_reg_vld,
  input  logic [HWW-1:0]           iss_hwid,
  input  logic [SW-1:0]            iss_waits,
  input  logic                     iss_store,
  input  logic                     iss_data_wide,
  input  logic                     iss_soff_reg,
  input  logic                     nop_valid,
  input  logic                     gen_sel,
  input  logic                     store_hz_en,
  input  logic [CW-1:0]            cand_class,
  input  logic [NREG-1:0][RW-1:0]  cand_src,
  input  logic [NREG-1:0]          cand_src_vld,
  input  logic [NREG-1:0][RW-1:0]  cand_dst,
  input  logic [NREG-1:0]          cand_dst_vld,
  input  logic [HWW-1:0]           cand_hwid,
  output logic [SW-1:0]            stall,
  output logic                     hazard
);
  localparam logic [SW-1:0] MAX_RULE = SW'(5);

  icls_e  i_cls, c_cls;
  slot_t  push_slot;
  logic   push_en;
  slot_t  hist [HIST];

  always_comb begin
    i_cls   = icls_e'(iss_class);
    c_cls   = icls_e'(cand_class);
    push_en = iss_valid && (i_cls != C_PH) && (i_cls != C_DBG);
    push_slot.vld      = 1'b1;
    push_slot.cls      = i_cls;
    push_slot.regs     = iss_regs;
    push_slot.rvld     = iss_reg_vld;
    push_slot.hwid     = iss_hwid;
    push_slot.is_store = iss_store;
    push_slot.hz_store = iss_store && iss_data_wide && !iss_soff_reg;
  end

  hzc_history u_hist (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_slot(push_slot),
    .push_waits(iss_waits), .nop_en(nop_valid), .hist(hist)
  );

  hzc_rules u_rules (
    .hist(hist), .c_cls(c_cls), .c_src(cand_src), .c_src_vld(cand_src_vld),
    .c_dst(cand_dst), .c_dst_vld(cand_dst_vld), .c_hwid(cand_hwid),
    .gen_sel(gen_sel), .store_hz_en(store_hz_en), .stall(stall)
  );

  assign hazard = (stall != '0);

  // R13
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall <= MAX_RULE);

  // R13
  free_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand_class == 4'd0) || (cand_class == 4'd1)) |-> !hazard);

  // R13
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stall == '0));
endmodule

// File: tb/hzc_waitcalc_bench.sv
module hzc_waitcalc_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, iss_store, iss_data_wide, iss_soff_reg, nop_valid, gen_sel, store_hz_en;
  logic [3:0] iss_class, cand_class, iss_reg_vld, cand_src_vld, cand_dst_vld;
  logic [3:0][7:0] iss_regs, cand_src, cand_dst;
  logic [5:0] iss_hwid, cand_hwid;
  logic [2:0] iss_waits, stall;
  logic hazard;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hzc_waitcalc u_hzc_waitcalc (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_regs(iss_regs), .iss_reg_vld(iss_reg_vld), .iss_hwid(iss_hwid),
    .iss_waits(iss_waits), .iss_store(iss_store), .iss_data_wide(iss_data_wide),
    .iss_soff_reg(iss_soff_reg), .nop_valid(nop_valid), .gen_sel(gen_sel),
    .store_hz_en(store_hz_en), .cand_class(cand_class), .cand_src(cand_src),
    .cand_src_vld(cand_src_vld), .cand_dst(cand_dst), .cand_dst_vld(cand_dst_vld),
    .cand_hwid(cand_hwid), .stall(stall), .hazard(hazard)
  );

  task automatic idle_inputs();
    iss_valid = 0; iss_class = 0; iss_regs = '0; iss_reg_vld = 0; iss_hwid = 0;
    iss_waits = 1; iss_store = 0; iss_data_wide = 0; iss_soff_reg = 0; nop_valid = 0;
  endtask

  task automatic clr_cand();
    cand_class = 0; cand_src = '0; cand_src_vld = 0; cand_dst = '0;
    cand_dst_vld = 0; cand_hwid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_inputs(); clr_cand(); gen_sel = 0; store_hz_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // one issue with a single register entry; ends at the following falling edge
  task automatic issue(input logic [3:0] c, input logic [7:0] r, input logic rv,
                       input logic [5:0] hw, input logic [2:0] w);
    iss_valid = 1; iss_class = c; iss_regs[0] = r; iss_reg_vld = {3'b0, rv};
    iss_hwid = hw; iss_waits = w;
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  task automatic store(input logic [7:0] r, input logic wide, input logic soff);
    iss_store = 1; iss_data_wide = wide; iss_soff_reg = soff;
    issue(4'd4, r, 1, 0, 1);
  endtask

  task automatic nop();
    nop_valid = 1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cand1(input logic [3:0] c, input int slot, input logic [7:0] r);
    clr_cand(); cand_class = c;
    if (slot >= 0) begin cand_src[slot] = r; cand_src_vld[slot] = 1; end
  endtask

  task automatic chk(input logic [2:0] exp, input string req);
    #1;
    n_chk++;
    if (stall !== exp || hazard !== (exp != 0)) begin
      n_fail++;
      $display("FAIL %s: stall=%0d hazard=%0d expected stall=%0d hazard=%0d",
               req, stall, hazard, exp, exp != 0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    cand1(4'd3, 0, 8'h05); chk(0, "R13 reset smem");
    cand1(4'd10, -1, 0);   chk(0, "R13 reset rfe");
  endtask

  task automatic t_smem();
    do_reset();
    issue(4'd2, 8'h05, 1, 0, 1);
    cand1(4'd3, 0, 8'h05); chk(4, "R4 dist0");
    idle();                chk(4, "R2 idle keeps window");
    nop();                 chk(3, "R3 nop one slot");
    issue(4'd1, 8'h00, 0, 0, 1); chk(2, "R4 dist2");
    cand1(4'd3, 0, 8'h06); chk(0, "R4 other reg");
  endtask

  task automatic t_waits();
    do_reset();
    issue(4'd2, 8'h09, 1, 0, 3);
    cand1(4'd3, 0, 8'h09); chk(2, "R1 waits3 smem");
    cand1(4'd4, 2, 8'h09); chk(3, "R1 waits3 vmem");
    issue(4'd2, 8'h0A, 1, 0, 7);
    cand1(4'd3, 1, 8'h0A); chk(0, "R1 capped smem");
    cand1(4'd4, 1, 8'h0A); chk(1, "R1 capped vmem");
    cand1(4'd4, 0, 8'h09); chk(0, "R1 shifted out");
    do_reset();
    issue(4'd2, 8'h09, 1, 0, 0);
    cand1(4'd3, 0, 8'h09); chk(4, "R1 waits0 as one");
  endtask

  task automatic t_vmem();
    do_reset();
    issue(4'd2, 8'h11, 1, 0, 1);
    cand1(4'd4, 3, 8'h11); chk(5, "R5 scalar src");
    issue(4'd2, 8'h89, 1, 0, 1);
    cand1(4'd4, 0, 8'h89); chk(0, "R5 vector src");
    cand1(4'd4, 0, 8'h11); chk(4, "R5 dist1");
  endtask

  task automatic t_ignore();
    do_reset();
    issue(4'd2, 8'h05, 1, 0, 1);
    issue(4'd11, 8'h00, 0, 0, 1);
    cand1(4'd3, 0, 8'h05); chk(4, "R2 placeholder");
    issue(4'd12, 8'h00, 0, 0, 3); chk(4, "R2 debug");
    nop_valid = 1;
    issue(4'd2, 8'h06, 1, 0, 1);
    cand1(4'd3, 0, 8'h05); chk(3, "R3 issue beats nop");
    cand1(4'd3, 0, 8'h06); chk(4, "R3 issue recorded");
  endtask

  task automatic t_dpp();
    do_reset();
    issue(4'd0, 8'h90, 1, 0, 1);
    cand1(4'd5, 1, 8'h90); chk(2, "R6 any writer");
    nop();                 chk(1, "R6 dist1");
    store(8'h90, 1, 0);    chk(0, "R6 dist2");
    do_reset();
    store(8'h91, 0, 0);
    cand1(4'd5, 0, 8'h91); chk(0, "R6 store ignored");
    issue(4'd2, 8'h7E, 1, 0, 1);
    cand1(4'd5, -1, 0);    chk(5, "R7 exec valu");
    issue(4'd1, 8'h7E, 1, 0, 1); chk(4, "R7 salu exec not a source");
  endtask

  task automatic t_div_lane();
    do_reset();
    issue(4'd6, 8'h6A, 1, 0, 1);
    cand1(4'd6, -1, 0);    chk(4, "R8 vcc");
    nop(); nop();          chk(2, "R8 dist2");
    do_reset();
    issue(4'd2, 8'h14, 1, 0, 1);
    cand1(4'd7, 1, 8'h14); chk(4, "R9 lane select");
    cand1(4'd7, 0, 8'h14); chk(0, "R9 other src");
  endtask

  task automatic t_hwreg();
    do_reset();
    issue(4'd9, 8'h00, 0, 6'd5, 1);
    clr_cand(); cand_class = 8; cand_hwid = 5; chk(2, "R10 read same id");
    cand_hwid = 6;                                chk(0, "R10 read other id");
    cand_class = 9; cand_hwid = 5; gen_sel = 0;   chk(1, "R10 write gen0");
    gen_sel = 1;                                  chk(2, "R10 write gen1");
    nop();                                        chk(1, "R10 write gen1 dist1");
    gen_sel = 0;
    do_reset();
    issue(4'd9, 8'h00, 0, 6'd3, 1);
    cand1(4'd10, -1, 0);                          chk(1, "R11 trap write");
    issue(4'd9, 8'h00, 0, 6'd4, 1);               chk(0, "R11 dist1");
  endtask

  task automatic t_store();
    do_reset();
    store(8'hA0, 1, 0);
    clr_cand(); cand_class = 2; cand_dst[2] = 8'hA0; cand_dst_vld = 4'b0100;
    store_hz_en = 1; chk(1, "R12 wide store");
    store_hz_en = 0; chk(0, "R12 disabled");
    store_hz_en = 1;
    do_reset(); store_hz_en = 1;
    store(8'hA0, 1, 1);
    clr_cand(); cand_class = 2; cand_dst[0] = 8'hA0; cand_dst_vld = 1; chk(0, "R12 soffset");
    store(8'hA0, 0, 0); chk(0, "R12 narrow");
    store_hz_en = 0;
  endtask

  task automatic t_max();
    do_reset();
    issue(4'd2, 8'h05, 1, 0, 1);
    nop();
    issue(4'd2, 8'h06, 1, 0, 1);
    clr_cand(); cand_class = 3;
    cand_src[0] = 8'h05; cand_src[3] = 8'h06; cand_src_vld = 4'b1001;
    chk(4, "R13 max of sources");
    cand_src_vld = 4'b0001; chk(2, "R13 single source");
    cand_class = 1; chk(0, "R13 flag low");
  endtask

  initial begin
    rst_n = 0; idle_inputs(); clr_cand(); gen_sel = 0; store_hz_en = 0;
    t_reset(); t_smem(); t_waits(); t_vmem(); t_ignore();
    t_dpp(); t_div_lane(); t_hwreg(); t_store(); t_max();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule